// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. There are four sources. The first is an external pin, which is synchronised and acts on its rising edge. The others are a configurable number of timer/event counter overflow pulses and one time-base tick pulse. Each source has a latched request flag and an enable bit. A global enable gates all of them. When the core reports an instruction boundary, the global enable is set and the hardware call stack has room, the highest-priority pending source is acknowledged. The block pulses an acknowledge that tells the core to push its program counter, and it supplies that source's fixed vector address.

Taking an interrupt clears the global enable, so by default a service routine cannot be interrupted. Requests that arrive in the meantime still latch and wait. A return-from-interrupt from the core sets the global enable again. Software reads and writes the flags and enables through a two-address register port. The global enable appears at bit 0 of both addresses, so one write can update the flags and the global enable together.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, all request flags, all enable bits, the global enable and `irq_ack` are 0.
- R2: A one-cycle high pulse on a timer overflow or time-base input sets that source's request flag at the next clock edge. This happens whatever the enable bits and the global enable are.
- R3: The external pin passes through a two-stage synchroniser. A low-to-high transition sets flag 0 at the third rising clock edge after the pin changes. A pin held high sets the flag only once, and a falling transition sets nothing.
- R4: A source is pending when its flag and its enable bit are both 1. An interrupt is taken only in a cycle where `core_ready` is 1, the global enable is 1 and at least one source is pending.
- R5: Source indices run from 0 to 3: external pin, timer 0, timer 1, time base. Among pending sources, the lowest index wins.
- R6: The clock edge that takes an interrupt sets `irq_ack` for exactly one cycle. The same edge loads `irq_src` with the winning index and loads `irq_vec` with 4*(index+1), which gives 0x004, 0x008, 0x00C and 0x010.
- R7: The edge that takes an interrupt clears the global enable and the winner's flag. All other flags are left as they were.
- R8: A one-cycle pulse on `reti` sets the global enable to 1 at the next edge.
- R9: While `stack_full` is 1, no interrupt is taken and the pending flags are kept. The first eligible cycle after it falls takes the interrupt.
- R10: Address 0 reads and writes {enable[3:0], global enable} in bits 4..1 and bit 0. Address 1 reads and writes {flag[3:0], global enable} in the same layout. Writing a 1 to a flag bit sets the flag and writing a 0 clears it.
- R11: If a source's event arrives in the same cycle that the source is acknowledged, its flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf | input | NUM_TMR | Timer/event counter overflow pulses |
| tb_tick | input | 1 | Time-base event pulse |
| core_ready | input | 1 | Core is at an instruction boundary |
| stack_full | input | 1 | Hardware call stack has no free entry |
| reti | input | 1 | Core executes return-from-interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enables, 1 flags |
| reg_wdata | input | NUM_TMR+3 | Register write data |
| reg_rdata | output | NUM_TMR+3 | Register read data (combinational) |
| irq_ack | output | 1 | Push program counter and jump, one-cycle pulse |
| irq_src | output | SRC_W | Index of the acknowledged source |
| irq_vec | output | PC_W | Vector address for the jump |

## Verification
The bench uses the default build: two timers, so four sources and a 5-bit register width, and an 11-bit program counter. With only four sources, it can try every nonzero combination of flags against every nonzero set of enables, which covers the whole priority and masking space. It can also read back every value of both registers in full. With this small build, the bench can also service a full set of requests one by one through return-from-interrupt, and it can place the edge cases of the stack-full hold and the same-cycle event at exact clock counts.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Vector of a source: fixed spacing starting one step above address zero.
  function automatic int unsigned vector_for(int unsigned idx, int unsigned step);
    return (idx + 1) * step;
  endfunction
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int NSRC = 4,
  localparam int RW = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            we,
  input  logic            addr,
  input  logic [RW-1:0]   wdata,
  input  logic            take,
  input  logic [NSRC-1:0] clr,
  input  logic            reti,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] en,
  output logic            gie,
  output logic [RW-1:0]   rdata
);
  logic [NSRC-1:0] flag_nx;

  // Software write first, then the acknowledge clear, then new events win.
  always_comb begin
    flag_nx = flags;
    if (we && addr) flag_nx = wdata[NSRC:1];
    if (take) flag_nx = flag_nx & ~clr;
    flag_nx = flag_nx | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
      gie   <= 1'b0;
    end else begin
      flags <= flag_nx;
      if (we && !addr) en <= wdata[NSRC:1];
      if (take)      gie <= 1'b0;
      else if (reti) gie <= 1'b1;
      else if (we)   gie <= wdata[0];
    end
  end

  assign rdata = addr ? {flags, gie} : {en, gie};
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC  = 4,
  parameter int SRC_W = 2
) (
  input  logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  grant,
  output logic [SRC_W-1:0] idx,
  output logic             any
);
  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = pend[0];
    end else begin : g_rest
      assign grant[i] = pend[i] & ~(|pend[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) idx = idx | SRC_W'(i);
  end

  assign any = |pend;
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
  parameter int NUM_TMR  = 2,
  parameter int PC_W     = 11,
  parameter int VEC_STEP = 4,
  localparam int NSRC  = NUM_TMR + 2,
  localparam int SRC_W = $clog2(NSRC),
  localparam int RW    = NSRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_pin,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic               tb_tick,
  input  logic               core_ready,
  input  logic               stack_full,
  input  logic               reti,
  input  logic               reg_we,
  input  logic               reg_addr,
  input  logic [RW-1:0]      reg_wdata,
  output logic [RW-1:0]      reg_rdata,
  output logic               irq_ack,
  output logic [SRC_W-1:0]   irq_src,
  output logic [PC_W-1:0]    irq_vec
);
  import intc_pkg::*;

  logic            ext_rise;
  logic [NSRC-1:0] src_evt;
  logic [NSRC-1:0] flags, en, pend, grant;
  logic [SRC_W-1:0] win_idx;
  logic            any_pend, gie, take;

  intc_edge_sync u_sync (
    .clk (clk), .rst_n (rst_n), .din (ext_pin), .rise (ext_rise)
  );

  assign src_evt = {tb_tick, tmr_ovf, ext_rise};

  intc_regs #(.NSRC(NSRC)) u_regs (
    .clk (clk), .rst_n (rst_n), .evt (src_evt),
    .we (reg_we), .addr (reg_addr), .wdata (reg_wdata),
    .take (take), .clr (grant), .reti (reti),
    .flags (flags), .en (en), .gie (gie), .rdata (reg_rdata)
  );

  assign pend = flags & en;

  intc_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .pend (pend), .grant (grant), .idx (win_idx), .any (any_pend)
  );

  assign take = core_ready & gie & ~stack_full & any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack <= 1'b0;
      irq_src <= '0;
      irq_vec <= '0;
    end else begin
      irq_ack <= take;
      if (take) begin
        irq_src <= win_idx;
        irq_vec <= PC_W'(vector_for(int'(win_idx), VEC_STEP));
      end
    end
  end
endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk #(
  parameter int NSRC     = 4,
  parameter int SRC_W    = 2,
  parameter int PC_W     = 11,
  parameter int VEC_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_ack,
  input logic [SRC_W-1:0] irq_src,
  input logic [PC_W-1:0]  irq_vec,
  input logic             gie,
  input logic             core_ready,
  input logic             stack_full,
  input logic             take,
  input logic [NSRC-1:0]  pend,
  input logic [NSRC-1:0]  grant,
  input logic [NSRC-1:0]  flags,
  input logic [NSRC-1:0]  src_evt
);
  // R4: an acknowledge follows a cycle with all gating conditions met
  a_r4_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(gie && core_ready && !stack_full && (pend != '0)));

  // R5: a single winner with no lower-index pending source
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones(grant) == 1 && (pend & NSRC'(grant - 1'b1)) == '0));

  // R6: vector matches the reported source
  a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (int'(irq_vec) == (int'(irq_src) + 1) * VEC_STEP));

  // R6: acknowledge lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R7: global enable is off during the acknowledge cycle
  a_r7_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !gie);

  // R9: a full stack blocks the next acknowledge
  a_r9_stack_block: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |=> !irq_ack);

  // R2 / R11: every event leaves its flag set
  a_r11_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((flags & $past(src_evt)) == $past(src_evt)));
endmodule

bind intc_ctrl intc_ctrl_chk #(
  .NSRC(NSRC), .SRC_W(SRC_W), .PC_W(PC_W), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk (clk), .rst_n (rst_n), .irq_ack (irq_ack), .irq_src (irq_src),
  .irq_vec (irq_vec), .gie (gie), .core_ready (core_ready),
  .stack_full (stack_full), .take (take), .pend (pend), .grant (grant),
  .flags (flags), .src_evt (src_evt)
);

// File: tb/intc_ctrl_bench.sv
`timescale 1ns/1ps
module intc_ctrl_bench;
  localparam int NUM_TMR = 2;
  localparam int NSRC = NUM_TMR + 2;
  localparam int RW = NSRC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pin = 1'b0;
  logic [NUM_TMR-1:0] tmr_ovf = '0;
  logic tb_tick = 1'b0;
  logic core_ready = 1'b0;
  logic stack_full = 1'b0;
  logic reti = 1'b0;
  logic reg_we = 1'b0;
  logic reg_addr = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic irq_ack;
  logic [1:0] irq_src;
  logic [10:0] irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_ctrl u_intc_ctrl (
    .clk (clk), .rst_n (rst_n), .ext_pin (ext_pin), .tmr_ovf (tmr_ovf),
    .tb_tick (tb_tick), .core_ready (core_ready), .stack_full (stack_full),
    .reti (reti), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_ack (irq_ack),
    .irq_src (irq_src), .irq_vec (irq_vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input int d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = RW'(d);
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < NSRC; i++) if (m[i]) return i;
    return -1;
  endfunction

  int v;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    rd(0, v); chk("R1 enables", v, 0);
    rd(1, v); chk("R1 flags", v, 0);
    chk("R1 ack", int'(irq_ack), 0);

    // R2 internal events latch with all enables off
    for (int s = 1; s < NSRC; s++) begin
      cyc();
      if (s <= NUM_TMR) tmr_ovf[s-1] = 1'b1; else tb_tick = 1'b1;
      cyc();
      tmr_ovf = '0; tb_tick = 1'b0;
      rd(1, v); chk("R2 flag set", v, 1 << (s + 1));
      chk("R4 no ack while disabled", int'(irq_ack), 0);
      wr(1, 0);
      rd(1, v); chk("R10 flag cleared by write", v, 0);
    end

    // R3 external edge timing
    ext_pin = 1'b1;
    cyc(); rd(1, v); chk("R3 edge+1", v, 0);
    cyc(); rd(1, v); chk("R3 edge+2", v, 0);
    cyc(); rd(1, v); chk("R3 edge+3", v, 2);
    wr(1, 0);
    repeat (5) cyc();
    rd(1, v); chk("R3 held high no resets", v, 0);
    ext_pin = 1'b0;
    repeat (5) cyc();
    rd(1, v); chk("R3 falling edge ignored", v, 0);

    // R10 full readback sweep of both registers
    for (int d = 0; d < (1 << RW); d++) begin
      wr(0, d); rd(0, v); chk("R10 reg0 readback", v, d);
      wr(1, d); rd(1, v); chk("R10 reg1 readback", v, d);
      rd(0, v); chk("R10 shared global enable", v & 1, d & 1);
    end
    wr(0, 0); wr(1, 0);

    // R4 R5 R6 R7 exhaustive flags x enables
    for (int f = 1; f < (1 << NSRC); f++) begin
      for (int e = 1; e < (1 << NSRC); e++) begin
        int p, w;
        wr(1, f << 1);
        wr(0, (e << 1) | 1);
        p = f & e;
        w = lowest(p);
        core_ready = 1'b1;
        cyc();
        core_ready = 1'b0;
        if (p == 0) begin
          chk("R4 no pending no ack", int'(irq_ack), 0);
          rd(0, v); chk("R4 gie kept", v & 1, 1);
        end else begin
          chk("R6 ack", int'(irq_ack), 1);
          chk("R5 src", int'(irq_src), w);
          chk("R6 vector", int'(irq_vec), 4 * (w + 1));
          rd(0, v); chk("R7 gie cleared", v & 1, 0);
          rd(1, v); chk("R7 winner flag cleared", v >> 1, f & ~(1 << w));
        end
        cyc();
        chk("R6 ack one cycle", int'(irq_ack), 0);
        wr(0, 0); wr(1, 0);
      end
    end

    // R8 service chain through reti
    wr(1, 15 << 1);
    wr(0, (15 << 1) | 1);
    core_ready = 1'b1;
    for (int k = 0; k < NSRC; k++) begin
      cyc();
      chk("R8 chain ack", int'(irq_ack), 1);
      chk("R8 chain order", int'(irq_src), k);
      reti = 1'b1;
      cyc();
      reti = 1'b0;
      chk("R8 ack gone", int'(irq_ack), 0);
      rd(0, v); chk("R8 gie restored", v & 1, 1);
    end
    cyc();
    chk("R8 nothing left", int'(irq_ack), 0);
    core_ready = 1'b0;
    wr(0, 0); wr(1, 0);

    // R9 stack full holds the request
    wr(1, 1 << 1);
    wr(0, (1 << 1) | 1);
    stack_full = 1'b1;
    core_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk("R9 blocked", int'(irq_ack), 0);
    end
    rd(1, v); chk("R9 flag kept", v, 3);
    stack_full = 1'b0;
    cyc();
    chk("R9 taken after release", int'(irq_ack), 1);
    chk("R9 src", int'(irq_src), 0);
    core_ready = 1'b0;
    cyc();
    wr(0, 0); wr(1, 0);

    // R11 event in the acknowledge cycle of the same source
    wr(1, 8 << 1);
    wr(0, (8 << 1) | 1);
    core_ready = 1'b1;
    tb_tick = 1'b1;
    cyc();
    tb_tick = 1'b0;
    core_ready = 1'b0;
    chk("R11 ack", int'(irq_ack), 1);
    chk("R11 src", int'(irq_src), 3);
    rd(1, v); chk("R11 flag kept", v, 8 << 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule